// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Hi/Lo Result Pair

This block is the integer multiply and divide engine of a 32-bit load/store RISC core. It takes one request made of an operation code and two operands. It runs the operation over a fixed number of clock cycles and places the result in two dedicated result registers, Hi and Lo. These registers sit apart from the general register file. A single shift-based engine serves all four operations. Signed operations are handled by converting the operands to magnitudes on the way in and restoring the signs on the way out.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as the unit is busy. A request presented while `req_ready` is low is not taken and is not queued. A requester that drops `req_valid` before the unit frees up has therefore had no effect. One that holds `req_valid` high is taken on the first edge at which `req_ready` is high again. The result side has no handshake. Hi and Lo are read at any time through a select input, and the read is a plain copy.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, Hi and Lo read as zero, `busy` and `done` are low, and `req_ready` is high.
- R2: A request is accepted only on a rising edge with `req_valid` and `req_ready` both high, and `req_ready` is low exactly while `busy` is high. The operation codes are 0 for signed multiply, 1 for unsigned multiply, 2 for signed divide and 3 for unsigned divide.
- R3: For code 1, Hi:Lo receives the 64-bit product of the operands taken as unsigned numbers, with the upper half in Hi.
- R4: For code 0, Hi:Lo receives the 64-bit two's-complement product of the operands taken as signed numbers.
- R5: For code 3 with a nonzero divisor, Lo receives the unsigned quotient and Hi the unsigned remainder.
- R6: For code 2 with a nonzero divisor, the quotient is truncated toward zero and goes to Lo. The remainder takes the sign of the dividend and goes to Hi. Dividing the most negative value by -1 gives Lo = 0x80000000 and Hi = 0.
- R7: `busy` rises on the edge after acceptance and stays high for exactly 33 clock cycles. Hi and Lo are written, and `done` pulses high for one cycle, on the 33rd rising edge after the accepting edge. `busy` is low in that same cycle.
- R8: A request presented while busy leaves no trace: the running operation's result is unchanged and no extra completion occurs.
- R9: Division by zero raises no trap. It completes with the same timing as any other operation, and the values it leaves in Hi and Lo are unspecified.
- R10: `rd_data` shows Hi when `rd_sel` is 1 and Lo when `rd_sel` is 0, and reading either register any number of times does not change it.
- R11: Hi and Lo keep their values between completions, including while a later operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 2 | Operation code (0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div) |
| req_a | input | 32 | Multiplicand or dividend |
| req_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: Hi and Lo were just written |
| rd_sel | input | 1 | Read select: 1 for Hi, 0 for Lo |
| rd_data | output | 32 | Copy of the selected result register |

## Verification
Every result is due exactly 33 rising edges after the edge that accepted its request. `busy` is seen high for 33 consecutive cycles in between, and `done` marks the cycle in which Hi and Lo carry the new values. The driver records the cycle number of the accepting edge with each expected Hi/Lo pair it queues. The monitor samples on falling edges, so it reads the outputs away from the active edge. When `done` appears, the monitor pops the oldest entry and checks the elapsed cycle count, the number of busy cycles and both registers. A `done` with nothing queued is reported as an extra completion.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    MD_MUL_S = 2'd0,
    MD_MUL_U = 2'd1,
    MD_DIV_S = 2'd2,
    MD_DIV_U = 2'd3
  } md_op_e;

  function automatic logic md_is_div(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic md_is_signed(input logic [1:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/muldiv_sign_prep.sv
module muldiv_sign_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         neg_a,
  output logic         neg_b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b
);
  import muldiv_pkg::*;

  logic sgn;
  assign sgn   = md_is_signed(op);
  assign neg_a = sgn & a[W-1];
  assign neg_b = sgn & b[W-1];
  assign mag_a = neg_a ? (~a + 1'b1) : a;
  assign mag_b = neg_b ? (~b + 1'b1) : b;
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_div,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] raw_hi,
  output logic [W-1:0] raw_lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  acc, qr, mreg;
  logic [CW-1:0] cnt;
  logic          running, div_mode, fin_q;

  logic [W:0]    add_sum;
  logic [W:0]    shl;
  logic [W+1:0]  dif;
  logic [W-1:0]  nxt_acc, nxt_qr;

  always_comb begin
    add_sum = {1'b0, acc} + (qr[0] ? {1'b0, mreg} : '0);
    shl     = {acc, qr[W-1]};
    dif     = {1'b0, shl} - {2'b00, mreg};
    if (div_mode) begin
      if (!dif[W+1]) begin
        nxt_acc = dif[W-1:0];
        nxt_qr  = {qr[W-2:0], 1'b1};
      end else begin
        nxt_acc = shl[W-1:0];
        nxt_qr  = {qr[W-2:0], 1'b0};
      end
    end else begin
      nxt_acc = add_sum[W:1];
      nxt_qr  = {add_sum[0], qr[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      qr       <= '0;
      mreg     <= '0;
      cnt      <= '0;
      running  <= 1'b0;
      div_mode <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        acc      <= '0;
        qr       <= opa;
        mreg     <= opb;
        cnt      <= '0;
        running  <= 1'b1;
        div_mode <= is_div;
      end else if (running) begin
        acc <= nxt_acc;
        qr  <= nxt_qr;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          running <= 1'b0;
          fin_q   <= 1'b1;
        end
      end
    end
  end

  assign busy   = running | fin_q;
  assign fin    = fin_q;
  assign raw_hi = acc;
  assign raw_lo = qr;

  // R8: the controller never restarts a running engine
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R7: iterations advance one per cycle without stalling
  assert_iter_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != LAST) |=> (running && cnt == $past(cnt) + 1'b1));

  // R7: finish is a single-cycle event that ends the run
  assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!fin && !running));
endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [2*W-1:0] prod, prod_fix;
  logic           flip;

  assign flip     = neg_a ^ neg_b;
  assign prod     = {raw_hi, raw_lo};
  assign prod_fix = flip ? (~prod + 1'b1) : prod;

  always_comb begin
    if (is_div) begin
      lo = flip  ? (~raw_lo + 1'b1) : raw_lo;
      hi = neg_a ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      hi = prod_fix[2*W-1:W];
      lo = prod_fix[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         done,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data
);
  import muldiv_pkg::*;

  logic         accept;
  logic         core_busy, core_fin;
  logic         p_neg_a, p_neg_b;
  logic [W-1:0] p_mag_a, p_mag_b;
  logic [W-1:0] raw_hi, raw_lo, fix_hi, fix_lo;
  logic         neg_a_q, neg_b_q, div_q, done_q;
  logic [W-1:0] hi_q, lo_q;

  assign req_ready = ~core_busy;
  assign accept    = req_valid & req_ready;

  muldiv_sign_prep #(.W(W)) u_prep (
    .op    (req_op),
    .a     (req_a),
    .b     (req_b),
    .neg_a (p_neg_a),
    .neg_b (p_neg_b),
    .mag_a (p_mag_a),
    .mag_b (p_mag_b)
  );

  muldiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .is_div (md_is_div(req_op)),
    .opa    (p_mag_a),
    .opb    (p_mag_b),
    .busy   (core_busy),
    .fin    (core_fin),
    .raw_hi (raw_hi),
    .raw_lo (raw_lo)
  );

  muldiv_sign_fix #(.W(W)) u_fix (
    .is_div (div_q),
    .neg_a  (neg_a_q),
    .neg_b  (neg_b_q),
    .raw_hi (raw_hi),
    .raw_lo (raw_lo),
    .hi     (fix_hi),
    .lo     (fix_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      div_q   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= core_fin;
      if (accept) begin
        neg_a_q <= p_neg_a;
        neg_b_q <= p_neg_b;
        div_q   <= md_is_div(req_op);
      end
      if (core_fin) begin
        hi_q <= fix_hi;
        lo_q <= fix_lo;
      end
    end
  end

  assign busy    = core_busy;
  assign done    = done_q;
  assign rd_data = rd_sel ? hi_q : lo_q;

  // R11: result registers move only on a completion
  assert_hilo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !core_fin |=> ($stable(hi_q) && $stable(lo_q)));

  // R7: completion is a one-cycle pulse seen after the unit frees up
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: an accepted request always starts an operation
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_a = '0, req_b = '0;
  logic        busy, done;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;

  always #10 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy), .done(done),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  typedef struct {
    logic [1:0]  op;
    logic [31:0] eh, el;
    bit          dz;
    int          acc;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0, busy_cnt = 0;
  bit rst_checked = 0, finished = 0, have_last = 0;
  logic [31:0] last_hi = '0, last_lo = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] eh,
                                output logic [31:0] el);
    longint sa, sb, p, qq, rr;
    logic [63:0] up;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    eh = '0; el = '0;
    case (op)
      2'd0: begin p = sa * sb; eh = p[63:32]; el = p[31:0]; end
      2'd1: begin up = {32'b0, a} * {32'b0, b}; eh = up[63:32]; el = up[31:0]; end
      2'd2: if (b != 0) begin qq = sa / sb; rr = sa % sb; el = qq[31:0]; eh = rr[31:0]; end
      default: if (b != 0) begin el = a / b; eh = a % b; end
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    model(op, a, b, it.eh, it.el);
    it.op = op;
    it.dz = op[1] && (b == 0);
    @(posedge clk);
    #1;
    it.acc = cyc;
    q.push_back(it);
    req_valid = 1'b0;
  endtask

  // R8: junk requests while busy must not be taken
  task automatic poke_busy(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0 && busy == 1'b1, "R2 ready low while busy", {31'b0, req_ready}, 32'd0);
      req_valid = 1'b1; req_op = 2'd1; req_a = 32'hDEAD_0000 + i; req_b = 32'h77;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      if (!rst_checked && cyc >= 2) begin
        rst_checked = 1;
        rd_sel = 1'b1; #1;
        chk(rd_data == 0, "R1 hi reset", rd_data, 32'd0);
        rd_sel = 1'b0; #1;
        chk(rd_data == 0, "R1 lo reset", rd_data, 32'd0);
        chk(!busy && !done && req_ready, "R1 control reset", {29'b0, busy, done, req_ready}, 32'd1);
      end
    end else begin
      if (busy) begin
        busy_cnt++;
        if (busy_cnt == 16 && have_last) begin
          rd_sel = 1'b1; #1;
          chk(rd_data == last_hi, "R11 hi held mid-run", rd_data, last_hi);
          rd_sel = 1'b0; #1;
          chk(rd_data == last_lo, "R11 lo held mid-run", rd_data, last_lo);
        end
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected completion", 32'd1, 32'd0);
        end else begin
          item_t it;
          logic [31:0] h1, l1, h2, l2;
          it = q.pop_front();
          chk(cyc - it.acc == LAT, it.dz ? "R9 latency" : "R7 latency", cyc - it.acc, LAT);
          chk(busy_cnt == LAT, "R7 busy cycles", busy_cnt, LAT);
          rd_sel = 1'b1; #1; h1 = rd_data;
          rd_sel = 1'b0; #1; l1 = rd_data;
          rd_sel = 1'b1; #1; h2 = rd_data;
          rd_sel = 1'b0; #1; l2 = rd_data;
          chk(h1 == h2 && l1 == l2, "R10 reads non-destructive", h2, h1);
          if (!it.dz) begin
            case (it.op)
              2'd0: begin chk(h1 == it.eh, "R4 hi", h1, it.eh); chk(l1 == it.el, "R4 lo", l1, it.el); end
              2'd1: begin chk(h1 == it.eh, "R3 hi", h1, it.eh); chk(l1 == it.el, "R3 lo", l1, it.el); end
              2'd2: begin chk(h1 == it.eh, "R6 hi", h1, it.eh); chk(l1 == it.el, "R6 lo", l1, it.el); end
              default: begin chk(h1 == it.eh, "R5 hi", h1, it.eh); chk(l1 == it.el, "R5 lo", l1, it.el); end
            endcase
          end
          last_hi = h1; last_lo = l1; have_last = 1;
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3 unsigned multiply
    issue(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(2'd1, 32'h1234_5678, 32'h9ABC_DEF0);
    // R4 signed multiply
    issue(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(2'd0, 32'h8000_0000, 32'h8000_0000);
    issue(2'd0, 32'hFFFF_FFF9, 32'd3);
    // R5 unsigned divide
    issue(2'd3, 32'd100, 32'd7);
    issue(2'd3, 32'hFFFF_FFFF, 32'd1);
    issue(2'd3, 32'd5, 32'd9);
    // R6 signed divide
    issue(2'd2, 32'hFFFF_FFF9, 32'd2);
    issue(2'd2, 32'd7, 32'hFFFF_FFFE);
    issue(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    issue(2'd2, 32'hFFFF_FFF8, 32'hFFFF_FFFD);
    // R9 divide by zero
    issue(2'd3, 32'd5, 32'd0);
    issue(2'd2, 32'hFFFF_FFFB, 32'd0);
    // R8 requests while busy are ignored
    issue(2'd1, 32'd3, 32'd4);
    poke_busy(3);
    // mixed random traffic
    for (int i = 0; i < 24; i++) begin
      logic [31:0] b;
      b = $urandom;
      if (b == 0) b = 32'd1;
      issue(2'($urandom_range(0, 3)), $urandom, (i % 3 == 0) ? (b >> 20) | 32'd1 : b);
    end
    while (q.size() != 0) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(!busy && !done, "R8 no extra completion", {30'b0, busy, done}, 32'd0);
    summary();
  end
endmodule